// File: doc/BRIEF.md
# Flash-Clear Direct-Mapped Tag Store

This block keeps the address tags of a direct-mapped cache that holds 16-bit words in front of a byte-addressed bus. The bus address is split by the surrounding controller. The word index, which is address bits IDX_W..1, picks one entry. The tag, which is the address bits above the index, is what gets stored and compared. Address bit 0 selects a byte within a word and takes no part in either field.

The stored tags cannot be read back. The block produces one combinational output, the match flag. It is high only when the entry at the presented index equals the presented tag together with a field of constant-one bits. A write stores the tag and sets that one-field. One clock cycle of bulk clear zeroes every entry at once. Because the one-field is then zero, no tag can match a cleared entry. The controller uses bulk clear whenever memory may have changed behind the cache.

For a 16 MB address space and 16 KB of cached words, set IDX_W = 13. That gives 8K entries with 10-bit tags, addresses 0x4000 apart share an entry, and 1024 memory words alias onto each entry. The default parameters elaborate a smaller array with the same address arithmetic.

Top module: `flash_tag_store`

## Requirements
- R1: While rst_n is low, and after it is released, every entry is empty: match_o is 0 for every index and every tag until a write occurs.
- R2: With wr_en_i high and clear_i low at a rising clock edge, tag_i is stored at index_i. From the next cycle, presenting that index and tag gives match_o = 1.
- R3: match_o is combinational from index_i, tag_i and the stored state. It follows a change of those inputs within the same cycle, with no clock edge between.
- R4: match_o is 1 only if every stored tag bit equals tag_i. A tag that differs from the stored one in any single bit gives 0.
- R5: Each entry carries VAL_W bits that every write sets to one and that clearing sets to zero. An entry that was never written, or was cleared, matches no tag, not even the all-zero tag.
- R6: With clear_i high at a rising clock edge, every entry is empty from the next cycle on.
- R7: Clear has priority. When clear_i and wr_en_i are both high at an edge, nothing is stored, and the written tag does not match in the next cycle.
- R8: A write changes only the entry at index_i. Every other index keeps its previous match result for every tag.
- R9: A write to an index that already holds a tag replaces it. The old tag no longer matches there.
- R10: Byte addresses that differ by a multiple of 2^(IDX_W+1) (0x4000 at IDX_W = 13) select the same entry. A write through one of them makes the others miss. Both bytes of one word share the same entry and tag.
- R11: At an edge with neither wr_en_i nor clear_i high, the stored state does not change: match_o for any index and tag stays as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clears take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, empties the array |
| clear_i | input | 1 | Bulk clear of all entries, sampled at the rising edge |
| wr_en_i | input | 1 | Store tag_i at index_i at the rising edge |
| index_i | input | IDX_W | Word index, address bits IDX_W..1 |
| tag_i | input | ADDR_W-IDX_W-1 | Upper address bits ADDR_W-1..IDX_W+1 |
| match_o | output | 1 | High when the entry at index_i equals tag_i and is valid |

## Verification
A small configuration is driven with exhaustive sweeps of every index against every tag. The sweeps run on an empty array, on an array filled with a distinct computed tag per index, and after a single-entry overwrite. Separating those three states shows whether a failure comes from the validity field, from the tag comparison or from the write decode. Byte addresses a multiple of the alias stride apart are used to show that entries are shared and told apart by the tag alone. Clear is applied alone and together with a write to show that it takes priority. Inputs are also changed without a clock edge to show that the match is combinational.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_CLEAR = 2'd2
  } tag_op_e;

  // Bulk clear wins over a write in the same cycle.
  function automatic tag_op_e decode_op(input logic clear, input logic wr);
    if (clear)   return OP_CLEAR;
    else if (wr) return OP_WRITE;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/tag_entry.sv
module tag_entry #(
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [ENT_W-1:0] wdata_i,
  output logic [ENT_W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (we_i)  q_o <= wdata_i;
  end
endmodule

// File: rtl/tag_row_decode.sv
module tag_row_decode #(
  parameter int IDX_W = 4,
  localparam int ROWS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             write_i,
  input  logic [IDX_W-1:0] index_i,
  output logic [ROWS-1:0]  row_we_o
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_we_o[g] = write_i && (index_i == IDX_W'(g));
  end

  AST_ROW_WE_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_we_o)); // R8
endmodule

// File: rtl/tag_compare.sv
module tag_compare #(
  parameter int TAG_W = 5,
  parameter int VAL_W = 2,
  localparam int ENT_W = TAG_W + VAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ENT_W-1:0] entry_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             match_o
);
  logic [VAL_W-1:0] sel_val;
  logic [TAG_W-1:0] sel_tag;
  logic             sel_valid_full;

  assign sel_val        = entry_i[ENT_W-1:TAG_W];
  assign sel_tag        = entry_i[TAG_W-1:0];
  assign sel_valid_full = &sel_val;
  assign match_o        = (entry_i == {{VAL_W{1'b1}}, tag_i});

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> sel_valid_full); // R5
  AST_HIT_TAG_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (sel_tag ^ tag_i) == '0); // R4
endmodule

// File: rtl/flash_tag_store.sv
module flash_tag_store #(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 11,
  parameter int VAL_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - 1,
  localparam int ENT_W = TAG_W + VAL_W,
  localparam int ROWS  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             match_o
);
  import tagstore_pkg::*;

  tag_op_e              op;
  logic                 do_clear;
  logic                 do_write;
  logic [ROWS-1:0]      row_we;
  logic [ENT_W-1:0]     wdata;
  logic [ENT_W-1:0]     entries [ROWS];
  logic [ENT_W-1:0]     sel_entry;

  assign op       = decode_op(clear_i, wr_en_i);
  assign do_clear = (op == OP_CLEAR);
  assign do_write = (op == OP_WRITE);
  assign wdata    = {{VAL_W{1'b1}}, tag_i};

  tag_row_decode #(.IDX_W(IDX_W)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .write_i  (do_write),
    .index_i  (index_i),
    .row_we_o (row_we)
  );

  for (genvar g = 0; g < ROWS; g++) begin : g_ent
    tag_entry #(.ENT_W(ENT_W)) u_ent (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (do_clear),
      .we_i    (row_we[g]),
      .wdata_i (wdata),
      .q_o     (entries[g])
    );
  end

  assign sel_entry = entries[index_i];

  tag_compare #(.TAG_W(TAG_W), .VAL_W(VAL_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .entry_i (sel_entry),
    .tag_i   (tag_i),
    .match_o (match_o)
  );

  AST_WRITE_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !clear_i) |=> (!($stable(index_i) && $stable(tag_i)) || match_o)); // R2
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !match_o); // R6
  AST_CLEAR_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && wr_en_i) |=> !match_o); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !clear_i) |=> (!($stable(index_i) && $stable(tag_i)) || $stable(match_o))); // R11
endmodule

// File: tb/flash_tag_store_tb.sv
`timescale 1ns/1ps
module flash_tag_store_tb;
  localparam int ADDR_W = 10;
  localparam int IDX_W  = 4;
  localparam int VAL_W  = 2;
  localparam int TAG_W  = ADDR_W - IDX_W - 1;
  localparam int ROWS   = 1 << IDX_W;
  localparam int TAGS   = 1 << TAG_W;
  localparam int STRIDE = 1 << (IDX_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [IDX_W-1:0] index_i = '0;
  logic [TAG_W-1:0] tag_i = '0;
  logic match_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int model [ROWS];   // -1 means empty

  always #2 clk = ~clk;

  flash_tag_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .VAL_W(VAL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .wr_en_i(wr_en_i),
    .index_i(index_i), .tag_i(tag_i), .match_o(match_o)
  );

  function automatic int idx_of(input int a);
    return (a >> 1) % ROWS;
  endfunction
  function automatic int tag_of(input int a);
    return (a / STRIDE) % TAGS;
  endfunction
  function automatic int fill_tag(input int i, input int salt);
    return (i * 7 + salt) % TAGS;
  endfunction

  task automatic probe(input int idx, input int tg, input bit exp, input string req);
    index_i = IDX_W'(idx);
    tag_i   = TAG_W'(tg);
    #0.1;
    checks++;
    if (match_o !== exp) begin
      fails++;
      $display("FAIL %s idx=%0d tag=%0d actual=%b expected=%b", req, idx, tg, match_o, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < ROWS; i++)
      for (int t = 0; t < TAGS; t++)
        probe(i, t, model[i] == t, req);
  endtask

  task automatic do_write(input int idx, input int tg);
    @(negedge clk);
    wr_en_i = 1'b1; index_i = IDX_W'(idx); tag_i = TAG_W'(tg);
    @(negedge clk);
    wr_en_i = 1'b0;
    model[idx] = tg;
  endtask

  task automatic model_clear();
    for (int i = 0; i < ROWS; i++) model[i] = -1;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    // R1 and R5: in reset and after release, nothing matches, including tag 0
    #5;
    probe(0, 0, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    sweep("R1/R5 empty after reset");

    // R2, R4, R8: fill every index with a distinct computed tag
    for (int i = 0; i < ROWS; i++) begin
      do_write(i, fill_tag(i, 3));
      if (i == 5) sweep("R8 partial fill");
    end
    sweep("R2/R4 full fill");
    // R4: single-bit differences miss
    for (int i = 0; i < ROWS; i++)
      for (int b = 0; b < TAG_W; b++)
        probe(i, fill_tag(i, 3) ^ (1 << b), 1'b0, "R4 one bit off");

    // R3: inputs move with no clock edge, match follows
    @(negedge clk);
    probe(2, fill_tag(2, 3), 1'b1, "R3 hit");
    #0.3; probe(2, fill_tag(2, 3) ^ 1, 1'b0, "R3 change no edge");
    #0.3; probe(2, fill_tag(2, 3), 1'b1, "R3 back no edge");

    // R9: overwrite index 9
    do_write(9, fill_tag(9, 3) ^ 5);
    probe(9, fill_tag(9, 3), 1'b0, "R9 old tag gone");
    sweep("R9/R8 after overwrite");

    // R11: idle edges with inputs moving keep contents
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      index_i = IDX_W'(k * 3); tag_i = TAG_W'(k);
    end
    sweep("R11 idle retains");

    // R6: single-cycle bulk clear
    @(negedge clk); clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
    model_clear();
    sweep("R6 clear empties");

    // R7: clear together with a write stores nothing
    do_write(4, 11);
    @(negedge clk);
    clear_i = 1'b1; wr_en_i = 1'b1; index_i = 7; tag_i = 13;
    @(negedge clk);
    clear_i = 1'b0; wr_en_i = 1'b0;
    model_clear();
    probe(7, 13, 1'b0, "R7 clear beats write");
    sweep("R7 all empty");

    // R10: aliasing through byte addresses
    begin
      int a0, a1;
      a0 = 6;
      a1 = a0 + STRIDE;
      do_write(idx_of(a0), tag_of(a0));
      probe(idx_of(a0), tag_of(a0), 1'b1, "R10 base hit");
      probe(idx_of(a0 + 1), tag_of(a0 + 1), 1'b1, "R10 odd byte same word");
      probe(idx_of(a1), tag_of(a1), 1'b0, "R10 alias miss");
      do_write(idx_of(a1), tag_of(a1));
      probe(idx_of(a1), tag_of(a1), 1'b1, "R10 alias hit");
      probe(idx_of(a0), tag_of(a0), 1'b0, "R10 base evicted");
      for (int m = 2; m < TAGS; m++)
        probe(idx_of(a0 + m * STRIDE), tag_of(a0 + m * STRIDE), 1'b0, "R10 other aliases");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule